// File: doc/BRIEF.md
# Reservation-Station Front End for a Shared Fixed-Latency Pipeline

This block lets several reservation stations share one fixed-latency execution pipeline. Each station has its own operand port and its own result port. When a station accepts a pair of operands it becomes busy. It then competes with the other stations for the single pipeline entry. A round-robin arbiter drives a fan-in multiplexer that picks which station issues in a given cycle.

Every pipeline stage carries a valid bit and the index of the issuing station next to the data. At the exit, that index steers the result back to the station that supplied the operands. The result waits there until the consumer acknowledges it. A station stays busy and cannot take new operands until its result has been acknowledged. Each station therefore has at most one operation in flight, and the pipeline never needs to stall. The execution body is a registered delay line whose first stage adds the two operands. It never sees station indices.

Two parameters make the capture points transparent. With `OPB` set, an idle station whose operands arrive can issue in the same cycle. With `RSB` set, a result is visible on the station's result port in the cycle it leaves the pipeline, and an acknowledge in that cycle frees the station at once.

Top module: `rs_pipe_front`

## Requirements
- R1: After reset, every bit of `op_ready` is 1 and every bit of `res_valid` is 0.
- R2: Each accepted operand pair (a, b) on station i produces exactly one result equal to (a + b) mod 2^W. That result appears only on station i's slice of `res_data` (bits i*W+W-1 down to i*W), and results of one station come back in the order the operands were accepted.
- R3: With `OPB`=1 and `RSB`=1 and no contention, operands taken at clock edge e produce `res_valid[i]`=1 right after edge e+DEPTH-1.
- R4: `op_ready[i]` is 0 from the edge that captures operands until the edge that takes `res_ack[i]` while `res_valid[i]` is 1. `op_ready[i]` and `res_valid[i]` are never 1 together.
- R5: While `res_valid[i]` is 1 and `res_ack[i]` is 0, both `res_valid[i]` and the station's `res_data` slice hold unchanged into the next cycle.
- R6: Among stations requesting issue in one cycle, the grant goes to the first one after the last granted station, scanning in rising index order with wrap-around. After reset, the scan starts at station 0.
- R7: A station completes at most one operation per DEPTH cycles, so throughput never exceeds NST/DEPTH results per cycle. With operands offered and results acknowledged at once, a station's issue-to-issue spacing is DEPTH+1 cycles.
- R8: At most one station issues per cycle. The number of stations waiting on the pipeline always equals the number of valid pipeline stages, so the pipeline never stalls.
- R9: While a station is busy, `op_valid[i]` and its operand slices have no effect: the result returned is computed from the operands captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | NST | Per-station operand valid |
| op_ready | output | NST | Per-station ready (station idle) |
| op_a | input | NST*W | First operand, W bits per station |
| op_b | input | NST*W | Second operand, W bits per station |
| res_valid | output | NST | Per-station result valid |
| res_data | output | NST*W | Result, W bits per station |
| res_ack | input | NST | Per-station result acknowledge |

## Verification
The bench builds the block with three stations, a five-stage pipeline, 16-bit operands and both transparent paths enabled. Because there are fewer stations than stages, the saturated run shows the occupancy cap directly. The three-station contention case exercises the wrap-around of the round-robin pointer. The width makes the modular wrap of the sum observable, and the depth makes the issue-to-result latency clearly measurable.

// File: rtl/rs_pipe_front.sv
module rs_pipe_front #(
  parameter int NST   = 3,
  parameter int DEPTH = 4,
  parameter int W     = 16,
  parameter bit OPB   = 1'b1,
  parameter bit RSB   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NST-1:0]   op_valid,
  output logic [NST-1:0]   op_ready,
  input  logic [NST*W-1:0] op_a,
  input  logic [NST*W-1:0] op_b,
  output logic [NST-1:0]   res_valid,
  output logic [NST*W-1:0] res_data,
  input  logic [NST-1:0]   res_ack
);
  localparam int TW = (NST > 1) ? $clog2(NST) : 1;

  typedef enum logic [1:0] {S_IDLE, S_HELD, S_FLY, S_DONE} st_t;

  st_t            st   [NST];
  logic [W-1:0]   ra   [NST];
  logic [W-1:0]   rb   [NST];
  logic [W-1:0]   rd   [NST];
  logic [NST-1:0] req, gnt, fly_vec;
  logic [TW-1:0]  gidx, ptr;
  logic           hit_any;
  logic [W-1:0]   ia, ib;

  logic [DEPTH-1:0] pv;
  logic [TW-1:0]    pt [DEPTH];
  logic [W-1:0]     pd [DEPTH];

  wire            ev = pv[DEPTH-1];
  wire [TW-1:0]   et = pt[DEPTH-1];
  wire [W-1:0]    ed = pd[DEPTH-1];
  wire            any_gnt = |gnt;

  always_comb begin
    for (int i = 0; i < NST; i++)
      req[i] = (st[i] == S_HELD) || (OPB && st[i] == S_IDLE && op_valid[i]);
  end

  always_comb begin
    gnt = '0;
    gidx = '0;
    hit_any = 1'b0;
    for (int k = 1; k <= NST; k++) begin
      int j;
      j = (int'(ptr) + k) % NST;
      if (!hit_any && req[j]) begin
        hit_any = 1'b1;
        gnt[j] = 1'b1;
        gidx = TW'(j);
      end
    end
  end

  assign ia = (st[gidx] == S_HELD) ? ra[gidx] : op_a[gidx*W +: W];
  assign ib = (st[gidx] == S_HELD) ? rb[gidx] : op_b[gidx*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= TW'(NST-1);
      pv  <= '0;
    end else begin
      if (any_gnt) ptr <= gidx;
      pv[0] <= any_gnt;
      for (int s = 1; s < DEPTH; s++) pv[s] <= pv[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pt[0] <= gidx;
    pd[0] <= ia + ib;
    for (int s = 1; s < DEPTH; s++) begin
      pt[s] <= pt[s-1];
      pd[s] <= pd[s-1];
    end
  end

  for (genvar i = 0; i < NST; i++) begin : g_st
    wire hit = ev && (et == TW'(i));

    assign op_ready[i]          = (st[i] == S_IDLE);
    assign fly_vec[i]           = (st[i] == S_FLY);
    assign res_valid[i]         = (st[i] == S_DONE) || (RSB && st[i] == S_FLY && hit);
    assign res_data[i*W +: W]   = (st[i] == S_DONE) ? rd[i] : ed;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[i] <= S_IDLE;
      end else begin
        case (st[i])
          S_IDLE: if (op_valid[i]) st[i] <= gnt[i] ? S_FLY : S_HELD;
          S_HELD: if (gnt[i]) st[i] <= S_FLY;
          S_FLY:  if (hit) st[i] <= (RSB && res_ack[i]) ? S_IDLE : S_DONE;
          default: if (res_ack[i]) st[i] <= S_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (st[i] == S_IDLE && op_valid[i]) begin
        ra[i] <= op_a[i*W +: W];
        rb[i] <= op_b[i*W +: W];
      end
      if (st[i] == S_FLY && hit) rd[i] <= ed;
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid[i] && !res_ack[i] |=> res_valid[i] && $stable(res_data[i*W +: W])); // R5
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid[i] |-> !op_ready[i]); // R4
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_FLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fly_vec) == $countones(pv)); // R8
  AST_EXIT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ev |-> fly_vec[et]); // R2
endmodule

// File: tb/rs_pipe_front_test.sv
module rs_pipe_front_test;
  localparam int NST = 3, DEPTH = 5, W = 16;

  logic clk = 0, rst_n = 0;
  logic [NST-1:0] op_valid = '0, res_ack = '1;
  logic [NST*W-1:0] op_a = '0, op_b = '0;
  logic [NST-1:0] op_ready, res_valid;
  logic [NST*W-1:0] res_data;

  always #4 clk = ~clk;

  rs_pipe_front #(.NST(NST), .DEPTH(DEPTH), .W(W), .OPB(1'b1), .RSB(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_data(res_data), .res_ack(res_ack));

  int total = 0, bad = 0, cyc = 0, last_pop = 0;
  int first_cyc [NST];
  int done_cnt  [NST];
  bit seen      [NST];
  logic [W-1:0] expq [NST][$];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial for (int s = 0; s < NST; s++) begin
    first_cyc[s] = 0; done_cnt[s] = 0; seen[s] = 0;
  end

  always @(negedge clk) if (rst_n) begin
    for (int s = 0; s < NST; s++) if (res_valid[s]) begin
      if (!seen[s]) begin seen[s] = 1; first_cyc[s] = cyc; end
      if (res_ack[s]) begin
        logic [W-1:0] e;
        if (expq[s].size() == 0) chk(0, "R2 unexpected result", int'(res_data[s*W +: W]), 0);
        else begin
          e = expq[s].pop_front();
          chk(res_data[s*W +: W] == e, "R2 result data", int'(res_data[s*W +: W]), int'(e));
        end
        seen[s] = 0; done_cnt[s]++; last_pop = cyc;
      end
    end
  end

  task automatic send(input int s, input logic [W-1:0] a, input logic [W-1:0] b, output int hs);
    do begin @(posedge clk); #2; end while (!op_ready[s]);
    op_valid[s] = 1'b1;
    op_a[s*W +: W] = a;
    op_b[s*W +: W] = b;
    expq[s].push_back(a + b);
    @(posedge clk); #2;
    hs = cyc;
    op_valid[s] = 1'b0;
  endtask

  task automatic wait_done(input int s, input int n);
    while (done_cnt[s] < n) @(posedge clk);
    #2;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

  initial begin
    int h0, h1, h2, t0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(op_ready == '1, "R1 ready after reset", int'(op_ready), 7);
    chk(res_valid == '0, "R1 no result after reset", int'(res_valid), 0);

    // R3 and R2 single station, uncontended; sum wraps
    send(0, 16'hFFFF, 16'h0002, h0);
    wait_done(0, 1);
    chk(first_cyc[0] == h0 + DEPTH - 1, "R3 latency", first_cyc[0] - h0, DEPTH - 1);

    // R6 three stations at once; last grant was 0, so order 1,2,0
    fork
      send(0, 16'h0100, 16'h0011, h0);
      send(1, 16'h1234, 16'h4321, h1);
      send(2, 16'h8000, 16'h8001, h2);
    join
    wait_done(0, 2); wait_done(1, 1); wait_done(2, 1);
    chk(first_cyc[1] == h1 + DEPTH - 1, "R6 station1 first", first_cyc[1] - h1, DEPTH - 1);
    chk(first_cyc[2] == h1 + DEPTH,     "R6 station2 second", first_cyc[2] - h1, DEPTH);
    chk(first_cyc[0] == h1 + DEPTH + 1, "R6 station0 third", first_cyc[0] - h1, DEPTH + 1);

    // R4 R5 R9 held result, busy station ignores new operands
    res_ack[1] = 1'b0;
    send(1, 16'h0A0A, 16'h0505, h1);
    @(posedge clk); #2;
    chk(op_ready[1] == 1'b0, "R4 busy after capture", int'(op_ready[1]), 0);
    op_valid[1] = 1'b1; op_a[W +: W] = 16'h7777; op_b[W +: W] = 16'h1111;
    repeat (2) begin @(posedge clk); #2; end
    op_valid[1] = 1'b0;
    while (!res_valid[1]) begin @(posedge clk); #2; end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(res_valid[1] == 1'b1, "R5 valid held", int'(res_valid[1]), 1);
      chk(res_data[W +: W] == 16'h0F0F, "R9 stale operands ignored", int'(res_data[W +: W]), 16'h0F0F);
      chk(op_ready[1] == 1'b0, "R4 busy while result held", int'(op_ready[1]), 0);
    end
    @(posedge clk); #2;
    res_ack[1] = 1'b1;
    wait_done(1, 2);
    @(posedge clk); #2;
    chk(op_ready[1] == 1'b1, "R4 ready after ack", int'(op_ready[1]), 1);

    // R7 saturated run: fewer stations than stages caps throughput
    t0 = cyc + 1;
    fork
      for (int n = 0; n < 10; n++) begin int h; send(0, W'(n * 37), W'(n + 900), h); end
      for (int n = 0; n < 10; n++) begin int h; send(1, W'(n * 1111), W'(n ^ 77), h); end
      for (int n = 0; n < 10; n++) begin int h; send(2, W'(n + 60000), W'(n * 3000), h); end
    join
    wait_done(0, 12); wait_done(1, 12); wait_done(2, 11);
    chk(last_pop - t0 >= 10 * DEPTH, "R7 throughput cap", last_pop - t0, 10 * DEPTH);
    chk(last_pop - t0 <= 10 * (DEPTH + 1) + NST + 2, "R7 spacing DEPTH+1", last_pop - t0, 10 * (DEPTH + 1));
    for (int s = 0; s < NST; s++)
      chk(expq[s].size() == 0, "R2 all results returned", expq[s].size(), 0);

    finished = 1;
    summary();
  end
endmodule